// File: doc/BRIEF.md
# NAND Read Strobe Generator

This block generates the read-enable strobe (RE#, active low) for an asynchronous single-data-rate NAND flash data bus. It also decides when each incoming byte is sampled. All timing is counted in host clock cycles.

Each chip select has its own set of four counts:
- how long RE# stays low;
- how long it stays high between bytes;
- how many cycles after each RE# fall the data bus is sampled;
- the minimum spacing between the final RE# rise and any later write-enable fall.

A command names a chip select and a byte count. The block selects that chip select's timing set and emits one RE# low pulse per byte. It returns each sampled byte with a one-cycle valid flag.

The sample point is counted from the RE# falling edge, not tied to the RE# rising edge. It may therefore land after RE# has already gone high again, in the window where the flash still holds its output. When the sample point lies beyond the end of a full read cycle, the next RE# fall is held back until the pending sample has been taken. A busy output covers the whole burst, the pending sample and the closing gap. A write sequencer next to this block waits for busy to drop before lowering WE#.

Top module: `nand_rd_strobe`

## Requirements
- R1: After reset, re_n is 1, busy is 0 and rd_valid is 0.
- R2: A command is accepted on a rising edge where cmd_valid is 1, busy is 0 and cmd_len is nonzero. re_n goes low on that edge. Every RE# low pulse lasts exactly the effective low count in cycles.
- R3: Between bytes of a burst, re_n stays high for the effective high count, unless R5 extends it.
- R4: The data bus is sampled on the edge that lies the effective capture delay after each RE# fall. rd_valid is 1 for exactly the one following cycle, and rd_data holds the byte present at that edge. The sample may fall after RE# has risen.
- R5: Successive RE# falls are spaced by the larger of (low + high) and the capture delay. A new fall never happens while an earlier sample is still pending.
- R6: A command of length N produces exactly N RE# low pulses and exactly N captured bytes.
- R7: busy rises on the accepting edge. It stays 1 until both conditions hold: the larger of the effective high count and the effective read-to-write count has elapsed after the last RE# rise, and the last sample has been taken. Commands presented while busy is 1 are ignored.
- R8: cfg_flat holds one 4*CNT_W-bit set per chip select, with set c at bits [c*4*CNT_W +: 4*CNT_W]. Within a set, the fields from the least significant end are: low count, high count, capture delay, read-to-write count. The set named by cmd_cs is captured at acceptance. Changes to cfg_flat during a burst have no effect on that burst.
- R9: A programmed count of zero behaves as a count of one.
- R10: A command with cmd_len of zero is ignored. busy stays 0 and re_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flat | input | NUM_CS*4*CNT_W | Timing sets for all chip selects, laid out as in R8 |
| cmd_valid | input | 1 | Command request |
| cmd_cs | input | CS_W | Chip select for the command |
| cmd_len | input | LEN_W | Number of bytes to read |
| io_data | input | DATA_W | Flash data bus |
| re_n | output | 1 | Read-enable strobe, active low |
| busy | output | 1 | Burst, pending sample or write gap in progress |
| rd_valid | output | 1 | One-cycle flag for a captured byte |
| rd_data | output | DATA_W | Captured byte |

## Verification
The hardest situation to reach is a capture delay longer than a whole read cycle. In that case a byte's sample is still pending when its RE# high time runs out, so the sequencer must stall the next fall. If this happens on the last byte, busy must outlast the write gap. The bench reaches this by sweeping the capture delay past every sum of low and high counts in a small configuration, including zero fields. It also swaps the timing sets and scrambles cfg_flat in the middle of bursts. A second, longer command is held on the command port during each burst. The reference timeline of falls, samples and busy end is computed arithmetically for every combination.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  // sequencer phases
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LOW  = 3'd1,
    S_HIGH = 3'd2,
    S_WAIT = 3'd3,
    S_GAP  = 3'd4
  } seq_state_e;

  // field slots inside one timing set, least significant first
  localparam int FLD_LO  = 0;
  localparam int FLD_HI  = 1;
  localparam int FLD_ACC = 2;
  localparam int FLD_R2W = 3;
  localparam int NUM_FLD = 4;
endpackage

// File: rtl/nrs_cfg_sel.sv
module nrs_cfg_sel
  import nrs_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CNT_W  = 4,
  parameter int CS_W   = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [CS_W-1:0]                 sel,
  input  logic [NUM_CS*NUM_FLD*CNT_W-1:0] cfg_flat,
  output logic [CNT_W-1:0]                lo_q,
  output logic [CNT_W-1:0]                hi_q,
  output logic [CNT_W-1:0]                acc_q,
  output logic [CNT_W-1:0]                gap_q
);
  localparam int SET_W = NUM_FLD * CNT_W;

  // a zero count stands for a single cycle
  function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  function automatic logic [CNT_W-1:0] max_cnt(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CNT_W-1:0] fld [NUM_CS][NUM_FLD];

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      assign fld[c][f] = cfg_flat[c*SET_W + f*CNT_W +: CNT_W];
    end
  end

  logic [CNT_W-1:0] nxt_lo, nxt_hi, nxt_acc, nxt_gap;

  always_comb begin
    nxt_lo  = eff_cnt(fld[sel][FLD_LO]);
    nxt_hi  = eff_cnt(fld[sel][FLD_HI]);
    nxt_acc = eff_cnt(fld[sel][FLD_ACC]);
    // closing gap also keeps the high time before a later read
    nxt_gap = max_cnt(nxt_hi, eff_cnt(fld[sel][FLD_R2W]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= CNT_W'(1);
      hi_q  <= CNT_W'(1);
      acc_q <= CNT_W'(1);
      gap_q <= CNT_W'(1);
    end else if (load) begin
      lo_q  <= nxt_lo;
      hi_q  <= nxt_hi;
      acc_q <= nxt_acc;
      gap_q <= nxt_gap;
    end
  end
endmodule

// File: rtl/nrs_capture.sv
module nrs_capture #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_now,
  input  logic [CNT_W-1:0]  acc,
  input  logic [DATA_W-1:0] io_data,
  output logic              cap_pend,
  output logic              cap_fire,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CNT_W-1:0] acc_cnt;

  assign cap_fire = cap_pend && (acc_cnt >= acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      cap_pend <= 1'b0;
    end else if (fall_now) begin
      acc_cnt  <= CNT_W'(1);
      cap_pend <= 1'b1;
    end else if (cap_fire) begin
      cap_pend <= 1'b0;
    end else if (cap_pend) begin
      acc_cnt  <= acc_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_fire;
      if (cap_fire) rd_data <= io_data;
    end
  end
endmodule

// File: rtl/nrs_seq.sv
module nrs_seq
  import nrs_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_take,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] gap,
  input  logic             cap_pend,
  input  logic             cap_fire,
  output logic             re_n,
  output logic             fall_now,
  output logic             busy,
  output logic [LEN_W-1:0] rem_cnt
);
  seq_state_e       state;
  logic [CNT_W-1:0] ph_cnt;
  logic             go_ok;
  logic             lo_done, hi_done, gap_done;

  // the next fall may proceed once no older sample is outstanding
  assign go_ok    = !cap_pend || cap_fire;
  assign lo_done  = (ph_cnt >= lo);
  assign hi_done  = (ph_cnt >= hi);
  assign gap_done = (ph_cnt >= gap);

  always_comb begin
    unique case (state)
      S_IDLE:  fall_now = cmd_take;
      S_HIGH:  fall_now = hi_done && go_ok;
      S_WAIT:  fall_now = go_ok;
      default: fall_now = 1'b0;
    endcase
  end

  assign busy = (state != S_IDLE) || cap_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      re_n    <= 1'b1;
      ph_cnt  <= '0;
      rem_cnt <= '0;
    end else if (fall_now) begin
      state  <= S_LOW;
      re_n   <= 1'b0;
      ph_cnt <= CNT_W'(1);
      if (state == S_IDLE) rem_cnt <= cmd_len;
    end else begin
      unique case (state)
        S_LOW: begin
          if (lo_done) begin
            re_n    <= 1'b1;
            ph_cnt  <= CNT_W'(1);
            rem_cnt <= rem_cnt - LEN_W'(1);
            state   <= (rem_cnt == LEN_W'(1)) ? S_GAP : S_HIGH;
          end else begin
            ph_cnt <= ph_cnt + CNT_W'(1);
          end
        end
        S_HIGH: begin
          if (hi_done) state <= S_WAIT;
          else         ph_cnt <= ph_cnt + CNT_W'(1);
        end
        S_GAP: begin
          if (gap_done) state <= S_IDLE;
          else          ph_cnt <= ph_cnt + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_rd_strobe.sv
module nand_rd_strobe
  import nrs_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CNT_W  = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CS*NUM_FLD*CNT_W-1:0] cfg_flat,
  input  logic                            cmd_valid,
  input  logic [CS_W-1:0]                 cmd_cs,
  input  logic [LEN_W-1:0]                cmd_len,
  input  logic [DATA_W-1:0]               io_data,
  output logic                            re_n,
  output logic                            busy,
  output logic                            rd_valid,
  output logic [DATA_W-1:0]               rd_data
);
  logic [CNT_W-1:0] lo_q, hi_q, acc_q, gap_q;
  logic             cmd_take;
  logic             fall_now;
  logic             cap_pend, cap_fire;
  logic [LEN_W-1:0] rem_cnt;

  assign cmd_take = cmd_valid && !busy && (cmd_len != '0);

  nrs_cfg_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(cmd_take), .sel(cmd_cs),
    .cfg_flat(cfg_flat),
    .lo_q(lo_q), .hi_q(hi_q), .acc_q(acc_q), .gap_q(gap_q)
  );

  nrs_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take), .cmd_len(cmd_len),
    .lo(lo_q), .hi(hi_q), .gap(gap_q),
    .cap_pend(cap_pend), .cap_fire(cap_fire),
    .re_n(re_n), .fall_now(fall_now), .busy(busy), .rem_cnt(rem_cnt)
  );

  nrs_capture #(.CNT_W(CNT_W), .DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .fall_now(fall_now), .acc(acc_q),
    .io_data(io_data),
    .cap_pend(cap_pend), .cap_fire(cap_fire),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/nrs_checker.sv
module nrs_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             re_n,
  input logic             busy,
  input logic             rd_valid,
  input logic             cmd_valid,
  input logic [LEN_W-1:0] cmd_len,
  input logic             cap_pend,
  input logic             cap_fire,
  input logic [LEN_W-1:0] rem_cnt
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4

  AST_FALL_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |-> (!$past(cap_pend) || $past(cap_fire))); // R5

  AST_LOW_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (rem_cnt != '0)); // R6

  AST_BUSY_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> busy); // R7

  AST_BUSY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> busy); // R7

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_len == '0) && !busy) |=> !busy); // R10
endmodule

bind nand_rd_strobe nrs_checker #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .re_n(re_n), .busy(busy), .rd_valid(rd_valid),
  .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cap_pend(cap_pend),
  .cap_fire(cap_fire), .rem_cnt(rem_cnt)
);

// File: tb/nand_rd_strobe_tb.sv
module nand_rd_strobe_tb_top;
  localparam int NUM_CS = 2;
  localparam int CNT_W  = 4;
  localparam int LEN_W  = 8;
  localparam int DATA_W = 8;
  localparam int SET_W  = 4 * CNT_W;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [NUM_CS*SET_W-1:0]   cfg_flat = '0;
  logic                      cmd_valid = 1'b0;
  logic [0:0]                cmd_cs = '0;
  logic [LEN_W-1:0]          cmd_len = '0;
  logic [DATA_W-1:0]         io_data = '0;
  logic                      re_n, busy, rd_valid;
  logic [DATA_W-1:0]         rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nand_rd_strobe #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .LEN_W(LEN_W),
                   .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .cmd_valid(cmd_valid),
    .cmd_cs(cmd_cs), .cmd_len(cmd_len), .io_data(io_data), .re_n(re_n),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int dat(input int base, input int t);
    return (t * 37 + base) & 8'hFF;
  endfunction

  // one burst with reference timeline computed from the requirements
  task automatic run_txn(input int cs, input int l, input int h, input int a,
                         input int r, input int n, input bit scramble,
                         input int base);
    int le, he, ae, ge, per, b, f0, caps;
    string tre;
    le = eff(l); he = eff(h); ae = eff(a); ge = (eff(r) > he) ? eff(r) : he;
    per = (le + he > ae) ? le + he : ae;                 // R5 fall spacing
    f0 = (n - 1) * per;                                  // last fall offset
    b = (f0 + le + ge > f0 + ae) ? f0 + le + ge : f0 + ae; // R7 busy end
    caps = 0;
    @(negedge clk);
    cfg_flat = '1;                                       // R8 other set differs
    cfg_flat[cs*SET_W +: SET_W] = {r[CNT_W-1:0], a[CNT_W-1:0],
                                   h[CNT_W-1:0], l[CNT_W-1:0]};
    cmd_valid = 1'b1;
    cmd_cs = cs[0:0];
    cmd_len = n[LEN_W-1:0];
    io_data = dat(base, 0)[DATA_W-1:0];
    @(posedge clk);
    for (int t = 0; t <= b + 2; t++) begin
      bit exp_low, exp_val;
      @(negedge clk);
      exp_low = 1'b0; exp_val = 1'b0;
      for (int k = 0; k < n; k++) begin
        if (t >= k * per && t < k * per + le) exp_low = 1'b1;
        if (t == k * per + ae) exp_val = 1'b1;
      end
      if (l == 0 || h == 0) tre = "R9";
      else if (scramble) tre = "R8";
      else if (exp_low) tre = "R2";
      else tre = "R3 R5";
      chk(re_n == !exp_low, tre, re_n, !exp_low);
      chk(rd_valid == exp_val, (a == 0) ? "R9 R4" : "R4", rd_valid, exp_val);
      if (exp_val) begin
        chk(rd_data == dat(base, t)[DATA_W-1:0], "R4 data", rd_data, dat(base, t));
        caps++;
      end
      chk(busy == (t < b), "R7", busy, (t < b));
      if (rd_valid) caps += 0;
      // second command while busy must be ignored (R7); config churn (R8)
      if (t == 0) begin
        cmd_len = 8'd5;
        if (scramble) cfg_flat = ~cfg_flat;
      end
      if (t == 1) cmd_valid = 1'b0;
      io_data = dat(base, t + 1)[DATA_W-1:0];
    end
    chk(caps == n, "R6", caps, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(re_n == 1'b1, "R1", re_n, 1);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: zero-length command
    cmd_valid = 1'b1; cmd_len = '0; cmd_cs = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(busy == 1'b0, "R10", busy, 0);
      chk(re_n == 1'b1, "R10", re_n, 1);
    end
    cmd_valid = 1'b0;
    // sweep, zero fields included (R9), capture delay beyond the cycle (R5)
    for (int l = 0; l < 4; l++)
      for (int h = 0; h < 4; h++)
        for (int a = 0; a < 8; a++)
          for (int ri = 0; ri < 2; ri++)
            run_txn((l + a) % 2, l, h, a, ri * 6, 1 + ((l + h + a) % 3),
                    bit'((a ^ h) & 1), l * 11 + h * 5 + a * 3 + ri);
    run_txn(1, 15, 15, 15, 15, 2, 1'b1, 77);
    run_txn(0, 1, 1, 15, 0, 3, 1'b0, 5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule